// File: doc/BRIEF.md
# Consecutive Over-Temperature Shutdown Monitor

This block watches three temperature channels and drives an active-low shutdown output. Every time a new set of readings arrives with its valid strobe, each channel's reading is compared with that channel's own upper limit. A channel is flagged only after a programmable run of back-to-back conversions above its limit. Once any channel is flagged, the output goes low. It is released only after every flagged channel has cooled below its limit less a shared hysteresis margin.

Each channel keeps a status bit that reflects its flagged state. An aggregate bit is the OR of the three status bits. Reading these outputs never clears them. They clear only through the cooling condition. The run length comes from a 3-bit code whose number of set bits, plus one, gives the required run.

Top module: `thermMonitor`

## Requirements
- R1: After reset, all channel status bits and the aggregate bit are 0 and `thermN` is 1.
- R2: On each conversion whose reading is strictly greater than the channel's limit, the channel's run count rises by one. When the run count reaches the target, that channel's status bit sets in the same update.
- R3: While `thermN` is high, a conversion whose reading is at or below the channel's limit returns that channel's run count to zero.
- R4: The run target is the number of ones in `runCode` plus one. So 000 needs 1 conversion, 001 needs 2, 011 needs 3, and 111 needs 4 (111 is the intended default).
- R5: While `thermN` is low, a conversion whose reading lies between the release level and the limit, both inclusive, leaves the channel's run count and status bit unchanged.
- R6: A conversion whose reading is strictly below the release level (limit minus `hystBand`) clears that channel's status bit and run count.
- R7: `thermAny` equals the OR of the status bits. `thermN` is its inverse, so it is low while any bit is set and high once all are clear.
- R8: When `hystBand` exceeds the limit, the release level saturates at 0, so no unsigned reading can clear that channel.
- R9: Cycles without `sampleValid` change no status bit and no output, whatever the readings are.
- R10: Each channel counts and flags on its own readings only. A channel's status bit sets only from its own run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe marking a new set of readings |
| reading | input | 3x8 | Per-channel temperature reading, unsigned |
| thermLimit | input | 3x8 | Per-channel upper limit |
| hystBand | input | 8 | Shared hysteresis margin |
| runCode | input | 3 | Consecutive-run code (ones count plus one) |
| thermN | output | 1 | Active-low shutdown output |
| chanStatus | output | 3 | Per-channel flagged status |
| thermAny | output | 1 | OR of the channel status bits |

## Verification
A wrong run count does not show at once. It shows at the conversion where the status bit sets one conversion too early or too late. For that reason the bench interrupts runs with readings exactly at the limit, and keeps runs going across the assertion of `thermN`. A broken hold or release shows on the first conversion inside or below the hysteresis band, as a status bit that clears or sticks. Every output is registered and is compared one cycle after each strobe.

// File: rtl/thermPkg.sv
package thermPkg;

  parameter int CNT_W = 3;

  typedef struct packed {
    logic over;
    logic below;
    logic nextHit;
  } chanFlagT;

  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic stSet;
    logic stClr;
  } chanStrobeT;

  function automatic logic [CNT_W-1:0] runTarget(input logic [2:0] code);
    return CNT_W'($countones(code)) + CNT_W'(1);
  endfunction

endpackage

// File: rtl/thermDatapath.sv
module thermDatapath
  import thermPkg::*;
#(
  parameter int CHANNELS = 3,
  parameter int TEMP_W   = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [CHANNELS-1:0][TEMP_W-1:0] reading,
  input  logic [CHANNELS-1:0][TEMP_W-1:0] thermLimit,
  input  logic [TEMP_W-1:0]               hystBand,
  input  logic [2:0]                      runCode,
  input  chanStrobeT [CHANNELS-1:0]       strobes,
  output chanFlagT   [CHANNELS-1:0]       flags,
  output logic [CHANNELS-1:0]             chanStatus
);

  localparam int CMP_W = CNT_W + 1;

  logic [CNT_W-1:0] target;
  assign target = runTarget(runCode);

  for (genvar g = 0; g < CHANNELS; g++) begin : gChan
    logic [TEMP_W-1:0] relLevel;
    logic [CNT_W-1:0]  runCnt;
    logic [CMP_W-1:0]  cntPlus;

    // release level saturates at zero
    assign relLevel = (thermLimit[g] >= hystBand) ? (thermLimit[g] - hystBand) : '0;
    assign cntPlus  = {1'b0, runCnt} + CMP_W'(1);

    assign flags[g].over    = reading[g] > thermLimit[g];
    assign flags[g].below   = reading[g] < relLevel;
    assign flags[g].nextHit = cntPlus >= {1'b0, target};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        runCnt <= '0;
      end else if (strobes[g].cntClr) begin
        runCnt <= '0;
      end else if (strobes[g].cntInc && (runCnt < target)) begin
        runCnt <= cntPlus[CNT_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        chanStatus[g] <= 1'b0;
      end else if (strobes[g].stSet) begin
        chanStatus[g] <= 1'b1;
      end else if (strobes[g].stClr) begin
        chanStatus[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/thermControl.sv
module thermControl
  import thermPkg::*;
#(
  parameter int CHANNELS = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleValid,
  input  chanFlagT   [CHANNELS-1:0] flags,
  input  logic [CHANNELS-1:0]       chanStatus,
  output chanStrobeT [CHANNELS-1:0] strobes,
  output logic                      thermAny,
  output logic                      thermN
);

  logic [CHANNELS-1:0] nextStatus;

  always_comb begin
    for (int i = 0; i < CHANNELS; i++) begin
      strobes[i].cntInc = sampleValid & flags[i].over;
      // once the pin is asserted, only the hysteresis release clears a run
      strobes[i].cntClr = sampleValid & ~flags[i].over &
                          (thermAny ? flags[i].below : 1'b1);
      strobes[i].stSet  = sampleValid & flags[i].over & flags[i].nextHit;
      strobes[i].stClr  = sampleValid & flags[i].below;
      if (strobes[i].stSet)      nextStatus[i] = 1'b1;
      else if (strobes[i].stClr) nextStatus[i] = 1'b0;
      else                       nextStatus[i] = chanStatus[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thermAny <= 1'b0;
      thermN   <= 1'b1;
    end else begin
      thermAny <= |nextStatus;
      thermN   <= ~(|nextStatus);
    end
  end

endmodule

// File: rtl/thermMonitor.sv
module thermMonitor
  import thermPkg::*;
#(
  parameter int CHANNELS = 3,
  parameter int TEMP_W   = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            sampleValid,
  input  logic [CHANNELS-1:0][TEMP_W-1:0] reading,
  input  logic [CHANNELS-1:0][TEMP_W-1:0] thermLimit,
  input  logic [TEMP_W-1:0]               hystBand,
  input  logic [2:0]                      runCode,
  output logic                            thermN,
  output logic [CHANNELS-1:0]             chanStatus,
  output logic                            thermAny
);

  chanFlagT   [CHANNELS-1:0] flags;
  chanStrobeT [CHANNELS-1:0] strobes;

  thermDatapath #(.CHANNELS(CHANNELS), .TEMP_W(TEMP_W)) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .reading    (reading),
    .thermLimit (thermLimit),
    .hystBand   (hystBand),
    .runCode    (runCode),
    .strobes    (strobes),
    .flags      (flags),
    .chanStatus (chanStatus)
  );

  thermControl #(.CHANNELS(CHANNELS)) uControl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .flags       (flags),
    .chanStatus  (chanStatus),
    .strobes     (strobes),
    .thermAny    (thermAny),
    .thermN      (thermN)
  );

endmodule

// File: rtl/thermMonitorChk.sv
module thermMonitorChk #(
  parameter int CHANNELS = 3,
  parameter int TEMP_W   = 8
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            sampleValid,
  input logic [CHANNELS-1:0][TEMP_W-1:0] reading,
  input logic [CHANNELS-1:0][TEMP_W-1:0] thermLimit,
  input logic [2:0]                      runCode,
  input logic                            thermN,
  input logic [CHANNELS-1:0]             chanStatus,
  input logic                            thermAny
);

  assert_any_is_or_R7: assert property (@(posedge clk) disable iff (!rstN)
    thermAny == (|chanStatus));

  assert_pin_inverse_R7: assert property (@(posedge clk) disable iff (!rstN)
    thermN == !thermAny);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(chanStatus) && $stable(thermN));

  for (genvar g = 0; g < CHANNELS; g++) begin : gChk
    assert_rise_over_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chanStatus[g]) |-> $past(sampleValid) && $past(reading[g] > thermLimit[g]));

    assert_fall_low_R6: assert property (@(posedge clk) disable iff (!rstN)
      $fell(chanStatus[g]) |-> $past(sampleValid) && $past(reading[g] < thermLimit[g]));

    assert_single_run_R4: assert property (@(posedge clk) disable iff (!rstN)
      (sampleValid && runCode == 3'b000 && reading[g] > thermLimit[g]) |=> chanStatus[g]);
  end

endmodule

bind thermMonitor thermMonitorChk #(.CHANNELS(CHANNELS), .TEMP_W(TEMP_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .reading     (reading),
  .thermLimit  (thermLimit),
  .runCode     (runCode),
  .thermN      (thermN),
  .chanStatus  (chanStatus),
  .thermAny    (thermAny)
);

// File: tb/sim_thermMonitor.sv
`timescale 1ns/1ps
module sim_thermMonitor;

  localparam real CLK_HALF = 4.0;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            sampleValid = 1'b0;
  logic [2:0][7:0] reading = '0;
  logic [2:0][7:0] thermLimit = {8'd70, 8'd70, 8'd70};
  logic [7:0]      hystBand = 8'd5;
  logic [2:0]      runCode = 3'b111;
  logic            thermN;
  logic [2:0]      chanStatus;
  logic            thermAny;

  int total = 0;
  int bad = 0;

  typedef struct {
    string      tag;
    logic [2:0] st;
  } expT;
  expT expQ[$];

  int         mCnt[3];
  logic [2:0] mSt = '0;
  logic       sawValid = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  thermMonitor u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .reading(reading),
    .thermLimit(thermLimit), .hystBand(hystBand), .runCode(runCode),
    .thermN(thermN), .chanStatus(chanStatus), .thermAny(thermAny)
  );

  task automatic checkOut(input string tag, input logic [2:0] st);
    total++;
    if (chanStatus !== st || thermAny !== (|st) || thermN !== ~(|st)) begin
      bad++;
      $display("FAIL %s: status=%b any=%b thermN=%b expected status=%b any=%b thermN=%b",
               tag, chanStatus, thermAny, thermN, st, |st, ~(|st));
    end
  endtask

  // reference model built from the requirements
  task automatic modelStep(input logic [2:0][7:0] r);
    int   tgt;
    logic asserted;
    tgt = $countones(runCode) + 1;
    asserted = |mSt;
    for (int i = 0; i < 3; i++) begin
      int rel;
      logic over, below;
      rel   = (thermLimit[i] >= hystBand) ? int'(thermLimit[i]) - int'(hystBand) : 0;
      over  = r[i] > thermLimit[i];
      below = int'(r[i]) < rel;
      if (over) begin
        if (mCnt[i] < tgt) mCnt[i]++;
        if (mCnt[i] >= tgt) mSt[i] = 1'b1;
      end else begin
        if (!asserted || below) mCnt[i] = 0;
        if (below) mSt[i] = 1'b0;
      end
    end
  endtask

  task automatic conv(input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] r2,
                      input string tag);
    expT e;
    reading = {r2, r1, r0};
    sampleValid = 1'b1;
    modelStep({r2, r1, r0});
    e.tag = tag;
    e.st  = mSt;
    expQ.push_back(e);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  always @(posedge clk) sawValid <= sampleValid;

  // monitor: compare one cycle after each strobe
  always @(negedge clk) begin
    if (sawValid) begin
      if (expQ.size() == 0) begin
        total++;
        bad++;
        $display("FAIL scoreboard: output update with no expected item");
      end else begin
        expT e;
        e = expQ.pop_front();
        checkOut(e.tag, e.st);
      end
    end
  end

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_HALF * 2 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 3; i++) mCnt[i] = 0;
    repeat (3) @(negedge clk);
    checkOut("R1 reset", 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after release", 3'b000);

    // default run of four
    runCode = 3'b111;
    repeat (3) conv(8'd71, 8'd60, 8'd60, "R2 run below target");
    conv(8'd70, 8'd60, 8'd60, "R3 equal to limit resets run");
    repeat (3) conv(8'd71, 8'd60, 8'd60, "R3 restarted run");
    conv(8'd71, 8'd60, 8'd60, "R2 fourth conversion sets");
    conv(8'd68, 8'd71, 8'd60, "R5 inside band holds / R10 other channel");
    conv(8'd64, 8'd68, 8'd60, "R6 below release clears / R7 pin released");
    repeat (2) conv(8'd60, 8'd71, 8'd60, "R5 held run continues");
    conv(8'd60, 8'd60, 8'd60, "R6 channel 1 clears");

    // run codes
    runCode = 3'b000;
    conv(8'd60, 8'd60, 8'd71, "R4 code 000 one conversion");
    conv(8'd60, 8'd60, 8'd50, "R6 channel 2 clears");
    runCode = 3'b001;
    repeat (2) conv(8'd60, 8'd71, 8'd60, "R4 code 001 two conversions");
    conv(8'd60, 8'd50, 8'd60, "R6 clear after code 001");
    runCode = 3'b011;
    repeat (3) conv(8'd60, 8'd71, 8'd60, "R4 code 011 three conversions");
    conv(8'd60, 8'd50, 8'd60, "R6 clear after code 011");

    // idle cycles ignore readings
    runCode = 3'b000;
    conv(8'd71, 8'd60, 8'd60, "R4 set before idle");
    reading = {8'd0, 8'd0, 8'd0};
    repeat (3) @(negedge clk);
    checkOut("R9 no strobe, no change", mSt);
    reading = {8'd99, 8'd99, 8'd99};
    repeat (2) @(negedge clk);
    checkOut("R9 no strobe, hot readings ignored", mSt);
    conv(8'd60, 8'd60, 8'd60, "R6 clear after idle");

    // saturated release level
    thermLimit[0] = 8'd3;
    hystBand = 8'd10;
    conv(8'd4, 8'd60, 8'd60, "R8 set with small limit");
    conv(8'd0, 8'd60, 8'd60, "R8 zero reading cannot clear");
    thermLimit[0] = 8'd70;
    hystBand = 8'd5;
    conv(8'd60, 8'd60, 8'd60, "R6 clear after limit restored");

    repeat (3) @(negedge clk);
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", expQ.size());
    end
    finishRun();
  end

endmodule